// File: doc/BRIEF.md
# Framebuffer scanout cache reader

The block copies one complete 16-bit-per-pixel frame (64x64 pixels, 8192 bytes) from external memory into an on-chip store. It then answers colour lookups for a display timing engine that runs on a separate, slower clock. On the memory side it acts as an AXI4 read master. A frame-start pulse from the video domain crosses into the memory domain through a toggle synchronizer. When the enable input is high, that pulse starts a fill of 256 single-beat requests of 256 bits each. Once the fill completes, a completion flag crosses back to the video domain through a two-flop synchronizer and becomes the cache-valid output.

On the video side, the timing engine presents a byte address. The block picks the 16-bit lane out of the stored beat, splits it into three 5-bit colour fields and widens each field to 8 bits. It forces black when the address lies beyond the frame or the cache is not yet valid. For monitoring, the memory domain keeps a count of accepted data beats and a count of non-OKAY responses.

The fill controller is a three-state machine:
- **IDLE**: waits for a start.
- **ADDR**: drives a read request.
- **DATA**: waits for the data beat.

Its transitions are:
- **IDLE→ADDR** (launch): a start pulse arrives while enabled.
- **ADDR→DATA** (granted): the request handshake completes.
- **ADDR→IDLE** (abort): enable is low.
- **DATA→ADDR** (next): a beat carrying last is accepted, beats remain and enable is high.
- **DATA→IDLE** (finish): the final beat is accepted, or enable is low at a beat boundary.

Top module: `fb_scanout_reader`

## Requirements
- R1: `ar_valid` can be high only in a cycle that follows a memory-clock edge at which `en` was high. A `frame_go` pulse while `en` is low never produces a request. A fill starts only from a `frame_go` pulse seen while `en` is high.
- R2: Every request has `ar_len`=0, `ar_size`=5 (32 bytes), `ar_burst`=2'b01 (incrementing) and `ar_id`=`AXI_ID`. Only one request is outstanding at a time. `ar_valid` and `ar_addr` stay stable until `ar_ready`. Beats are requested in ascending order, 0 to 255.
- R3: The request for beat k carries address `BASE` + 32*k on the 30-bit address bus.
- R4: For byte address A, the pixel index is A>>1, the beat is (A>>1)/16 and the lane is (A>>1)%16. The pixel occupies bits [16*lane+15:16*lane] of that beat, and bit 0 of A is ignored.
- R5: Red is taken from pixel bits [4:0], green from [9:5] and blue from [14:10]. Each 5-bit field c becomes {c, c[4:2]}.
- R6: A lookup at a byte address of 8192 or above returns 0 on all three colour outputs.
- R7: Until a fill has completed, `cache_ok` is low and every lookup returns black.
- R8: The colour for an address presented before a video-clock rising edge appears after the second rising edge, and not after the first.
- R9: `beat_cnt` rises by one for each accepted data beat and reads 256 after one complete fill.
- R10: `err_cnt` rises by one for each accepted beat whose `r_resp` is not 2'b00, and stays 0 for a clean fill.
- R11: A `frame_go` pulse that arrives while a fill is running is ignored, and no extra beats are fetched.
- R12: An active-low `mem_rst_n` clears `beat_cnt`, `err_cnt`, the completion flag, `cache_ok`, the colour outputs and the fill state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory-side clock |
| mem_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| en | input | 1 | Fill enable, memory domain |
| vid_clk | input | 1 | Video-side clock |
| frame_go | input | 1 | One-cycle frame-start pulse, video domain |
| pix_addr | input | 32 | Byte address of the pixel to look up |
| red | output | 8 | Expanded red value |
| grn | output | 8 | Expanded green value |
| blu | output | 8 | Expanded blue value |
| cache_ok | output | 1 | Fill complete, synchronized to the video domain |
| beat_cnt | output | 32 | Accepted data beats since reset |
| err_cnt | output | 32 | Non-OKAY responses since reset |
| ar_addr | output | 30 | Read request address |
| ar_burst | output | 2 | Burst type |
| ar_id | output | 7 | Transaction ID |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Log2 of bytes per beat |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| r_data | input | 256 | Read data beat |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Last beat of burst |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |

## Verification
The final beat of a fill does three things in one memory-clock cycle: it bumps the beat counter, it ends the fill and sets the completion flag, and, if it carries an error response, it bumps the error counter as well. The bench provokes this on a second fill by returning a slave-error response on beat 255 only, with fresh pixel data. It then requires `beat_cnt` to be 512 and `err_cnt` to be exactly 1, and it requires lookups across the whole frame to show the new data. A `frame_go` injected in the middle of a fill is also judged by the beat total staying at 256.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_ADDR = 2'd1,
        F_DATA = 2'd2
    } fill_st_t;

    localparam logic [1:0] RESP_OK    = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;

    // widen a 5-bit channel to 8 bits by repeating its top bits
    function automatic logic [7:0] widen5(input logic [4:0] c);
        return {c, c[4:2]};
    endfunction

endpackage

// File: rtl/fbs_pulse_xing.sv
module fbs_pulse_xing #(
    parameter int STAGES = 3
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic              tgl;
    logic [STAGES-1:0] sh;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= tgl ^ src_pulse;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], tgl};
    end

    assign dst_pulse = sh[STAGES-1] ^ sh[STAGES-2];
endmodule

// File: rtl/fbs_level_sync.sv
module fbs_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/fbs_fill_ctrl.sv
module fbs_fill_ctrl
    import fbs_pkg::*;
#(
    parameter int                ADDR_W     = 30,
    parameter logic [ADDR_W-1:0] BASE       = '0,
    parameter int                BEATS      = 256,
    parameter int                BEAT_BYTES = 32,
    parameter int                ID_W       = 7,
    parameter int                AXI_ID     = 0,
    parameter int                CNT_W      = 32,
    localparam int               IDX_W      = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [ID_W-1:0]   ar_id,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic              ar_valid,
    input  logic              ar_ready,
    input  logic [1:0]        r_resp,
    input  logic              r_last,
    input  logic              r_valid,
    output logic              r_ready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              filled,
    output logic [CNT_W-1:0]  beat_cnt,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int               OFF_W = $clog2(BEAT_BYTES);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(BEATS - 1);

    fill_st_t         st, nxt;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             at_last;

    assign at_last = (idx_q == LAST);
    assign accept  = (st == F_DATA) && r_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            F_IDLE: if (start && en) nxt = F_ADDR;
            F_ADDR: begin
                if (!en)           nxt = F_IDLE;
                else if (ar_ready) nxt = F_DATA;
            end
            F_DATA: begin
                if (r_valid && r_last) begin
                    if (at_last || !en) nxt = F_IDLE;
                    else                nxt = F_ADDR;
                end
            end
            default: nxt = F_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ar_valid = (st == F_ADDR);
        r_ready  = (st == F_DATA);
        ar_addr  = BASE + (ADDR_W'(idx_q) << OFF_W);
        ar_len   = 8'd0;
        ar_size  = 3'(OFF_W);
        ar_burst = BURST_INCR;
        ar_id    = ID_W'(AXI_ID);
        wr_en    = accept;
        wr_idx   = idx_q;
    end

    // beat index, completion flag and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            filled   <= 1'b0;
            beat_cnt <= '0;
            err_cnt  <= '0;
        end else begin
            if (st == F_IDLE && nxt == F_ADDR) idx_q <= '0;
            if (accept) begin
                beat_cnt <= beat_cnt + 1'b1;
                if (r_resp != RESP_OK) err_cnt <= err_cnt + 1'b1;
                if (r_last) begin
                    if (at_last) begin
                        filled <= 1'b1;
                        idx_q  <= '0;
                    end else begin
                        idx_q  <= idx_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fbs_line_store.sv
module fbs_line_store #(
    parameter int  DEPTH = 256,
    parameter int  WIDTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
        rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/fbs_pixel_path.sv
module fbs_pixel_path
    import fbs_pkg::*;
#(
    parameter int  BEATS   = 256,
    parameter int  BEAT_W  = 256,
    parameter int  PIX_W   = 16,
    parameter int  ABITS   = 32,
    localparam int IDX_W   = $clog2(BEATS),
    localparam int LANES   = BEAT_W / PIX_W,
    localparam int LANE_W  = $clog2(LANES),
    localparam int BYTE_SH = $clog2(PIX_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ABITS-1:0]  pix_addr,
    input  logic              ok,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [BEAT_W-1:0] rd_data,
    output logic [7:0]        red,
    output logic [7:0]        grn,
    output logic [7:0]        blu
);
    localparam int               FRAME_BYTES = BEATS * BEAT_W / 8;
    localparam logic [ABITS-1:0] LIMIT       = ABITS'(FRAME_BYTES);

    logic [LANE_W-1:0] lane_q;
    logic              blank_q;
    logic [14:0]       px;

    assign rd_idx = pix_addr[BYTE_SH+LANE_W +: IDX_W];
    assign px     = rd_data[lane_q*PIX_W +: 15];

    // stage 1: lane and blanking decision, alongside the store read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q  <= '0;
            blank_q <= 1'b1;
        end else begin
            lane_q  <= pix_addr[BYTE_SH +: LANE_W];
            blank_q <= !ok || (pix_addr >= LIMIT);
        end
    end

    // stage 2: channel split and widening
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            red <= '0;
            grn <= '0;
            blu <= '0;
        end else if (blank_q) begin
            red <= '0;
            grn <= '0;
            blu <= '0;
        end else begin
            red <= widen5(px[4:0]);
            grn <= widen5(px[9:5]);
            blu <= widen5(px[14:10]);
        end
    end
endmodule

// File: rtl/fb_scanout_reader.sv
module fb_scanout_reader
    import fbs_pkg::*;
#(
    parameter int                ADDR_W = 30,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter int                BEATS  = 256,
    parameter int                BEAT_W = 256,
    parameter int                PIX_W  = 16,
    parameter int                ID_W   = 7,
    parameter int                AXI_ID = 0,
    parameter int                CNT_W  = 32
) (
    input  logic              mem_clk,
    input  logic              mem_rst_n,
    input  logic              en,
    input  logic              vid_clk,
    input  logic              frame_go,
    input  logic [31:0]       pix_addr,
    output logic [7:0]        red,
    output logic [7:0]        grn,
    output logic [7:0]        blu,
    output logic              cache_ok,
    output logic [CNT_W-1:0]  beat_cnt,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [ID_W-1:0]   ar_id,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic              ar_valid,
    input  logic              ar_ready,
    input  logic [BEAT_W-1:0] r_data,
    input  logic [1:0]        r_resp,
    input  logic              r_last,
    input  logic              r_valid,
    output logic              r_ready
);
    localparam int IDX_W      = $clog2(BEATS);
    localparam int BEAT_BYTES = BEAT_W / 8;

    logic             start_m;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [BEAT_W-1:0] rd_data;
    logic             filled;

    fbs_pulse_xing #(.STAGES(3)) u_go_xing (
        .src_clk   (vid_clk),
        .dst_clk   (mem_clk),
        .rst_n     (mem_rst_n),
        .src_pulse (frame_go),
        .dst_pulse (start_m)
    );

    fbs_fill_ctrl #(
        .ADDR_W     (ADDR_W),
        .BASE       (BASE),
        .BEATS      (BEATS),
        .BEAT_BYTES (BEAT_BYTES),
        .ID_W       (ID_W),
        .AXI_ID     (AXI_ID),
        .CNT_W      (CNT_W)
    ) u_fill (
        .clk      (mem_clk),
        .rst_n    (mem_rst_n),
        .en       (en),
        .start    (start_m),
        .ar_addr  (ar_addr),
        .ar_burst (ar_burst),
        .ar_id    (ar_id),
        .ar_len   (ar_len),
        .ar_size  (ar_size),
        .ar_valid (ar_valid),
        .ar_ready (ar_ready),
        .r_resp   (r_resp),
        .r_last   (r_last),
        .r_valid  (r_valid),
        .r_ready  (r_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .filled   (filled),
        .beat_cnt (beat_cnt),
        .err_cnt  (err_cnt)
    );

    fbs_line_store #(.DEPTH(BEATS), .WIDTH(BEAT_W)) u_store (
        .wr_clk  (mem_clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (r_data),
        .rd_clk  (vid_clk),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    fbs_level_sync #(.STAGES(2)) u_ok_sync (
        .clk   (vid_clk),
        .rst_n (mem_rst_n),
        .d     (filled),
        .q     (cache_ok)
    );

    fbs_pixel_path #(
        .BEATS  (BEATS),
        .BEAT_W (BEAT_W),
        .PIX_W  (PIX_W),
        .ABITS  (32)
    ) u_pix (
        .clk      (vid_clk),
        .rst_n    (mem_rst_n),
        .pix_addr (pix_addr),
        .ok       (cache_ok),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .red      (red),
        .grn      (grn),
        .blu      (blu)
    );
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
    parameter int ADDR_W = 30,
    parameter int BEATS  = 256,
    parameter int BEAT_W = 256,
    parameter int CNT_W  = 32
) (
    input logic              mem_clk,
    input logic              mem_rst_n,
    input logic              vid_clk,
    input logic              en,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic              r_valid,
    input logic              r_ready,
    input logic [1:0]        r_resp,
    input logic [CNT_W-1:0]  beat_cnt,
    input logic [CNT_W-1:0]  err_cnt,
    input logic [31:0]       pix_addr,
    input logic              cache_ok,
    input logic [7:0]        red,
    input logic [7:0]        grn,
    input logic [7:0]        blu
);
    localparam logic [31:0] LIMIT = 32'(BEATS * BEAT_W / 8);

    // R1
    ar_needs_en_chk: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        ar_valid |-> $past(en));

    // R2
    ar_hold_chk: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        (ar_valid && !ar_ready && en) |=> (ar_valid && $stable(ar_addr)));

    // R9
    beat_step_chk: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        (r_valid && r_ready) |=> (beat_cnt == $past(beat_cnt) + 1'b1));

    // R10
    err_step_chk: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        (r_valid && r_ready && r_resp != 2'b00) |=> (err_cnt == $past(err_cnt) + 1'b1));

    // R10
    err_hold_chk: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        !(r_valid && r_ready && r_resp != 2'b00) |=> $stable(err_cnt));

    // R6
    range_black_chk: assert property (@(posedge vid_clk) disable iff (!mem_rst_n)
        ($past(pix_addr, 2) >= LIMIT) |-> (red == 8'd0 && grn == 8'd0 && blu == 8'd0));

    // R7
    invalid_black_chk: assert property (@(posedge vid_clk) disable iff (!mem_rst_n)
        !$past(cache_ok, 2) |-> (red == 8'd0 && grn == 8'd0 && blu == 8'd0));
endmodule

bind fb_scanout_reader fbs_chk #(
    .ADDR_W (ADDR_W),
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W),
    .CNT_W  (CNT_W)
) u_fbs_chk (.*);

// File: tb/tb_fb_scanout_reader.sv
`timescale 1ns/1ps
module tb_fb_scanout_reader;
    localparam logic [29:0] BASE  = 30'h0004_0000;
    localparam int          BEATS = 256;

    logic mem_clk = 1'b0;
    logic vid_clk = 1'b0;
    always #5  mem_clk = ~mem_clk;   // 100 MHz
    always #13 vid_clk = ~vid_clk;

    logic         mem_rst_n, en, frame_go;
    logic [31:0]  pix_addr;
    logic [7:0]   red, grn, blu;
    logic         cache_ok;
    logic [31:0]  beat_cnt, err_cnt;
    logic [29:0]  ar_addr;
    logic [1:0]   ar_burst;
    logic [6:0]   ar_id;
    logic [7:0]   ar_len;
    logic [2:0]   ar_size;
    logic         ar_valid, ar_ready;
    logic [255:0] r_data;
    logic [1:0]   r_resp;
    logic         r_last, r_valid, r_ready;

    fb_scanout_reader #(.BASE(BASE), .AXI_ID(5)) dut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] salt;
    int err_beat;

    function automatic logic [15:0] pv(input int n, input logic [15:0] s);
        return 16'(n * 40503) ^ s;
    endfunction

    function automatic logic [255:0] beat_data(input int b, input logic [15:0] s);
        logic [255:0] d;
        for (int i = 0; i < 16; i++) d[16*i +: 16] = pv(b * 16 + i, s);
        return d;
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [31:0] a, input logic [15:0] s,
                                            input logic ok);
        logic [15:0] p;
        if (!ok || a >= 32'd8192) return 24'h0;
        p = pv(int'(a >> 1), s);
        return {p[4:0], p[4:2], p[9:5], p[9:7], p[14:10], p[14:12]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- memory slave model ----
    int sl_st, sl_dly, sl_beat;
    always @(posedge mem_clk or negedge mem_rst_n) begin
        if (!mem_rst_n) begin
            sl_st <= 0; sl_dly <= 0; sl_beat <= 0;
            ar_ready <= 1'b0; r_valid <= 1'b0; r_last <= 1'b0;
            r_data <= '0; r_resp <= 2'b00;
        end else begin
            case (sl_st)
                0: if (ar_valid) begin
                       if (sl_dly == 0) begin ar_ready <= 1'b1; sl_st <= 1; end
                       else sl_dly <= sl_dly - 1;
                   end
                1: if (ar_valid && ar_ready) begin
                       sl_beat  <= int'((ar_addr - BASE) >> 5);
                       ar_ready <= 1'b0;
                       sl_dly   <= int'($urandom % 4);
                       sl_st    <= 2;
                   end
                2: if (sl_dly == 0) begin
                       r_valid <= 1'b1; r_last <= 1'b1;
                       r_data  <= beat_data(sl_beat, salt);
                       r_resp  <= (sl_beat == err_beat) ? 2'b10 : 2'b00;
                       sl_st   <= 3;
                   end else sl_dly <= sl_dly - 1;
                default: if (r_ready) begin
                       r_valid <= 1'b0; r_last <= 1'b0;
                       sl_dly  <= int'($urandom % 3);
                       sl_st   <= 0;
                   end
            endcase
        end
    end

    // ---- request monitor ----
    int ar_cycles = 0;
    int bad_ar = 0;
    int exp_idx = 0;
    always @(posedge mem_clk) begin
        if (mem_rst_n && ar_valid) ar_cycles <= ar_cycles + 1;
        if (mem_rst_n && ar_valid && ar_ready) begin
            if (ar_len != 8'd0 || ar_size != 3'd5 || ar_burst != 2'b01 || ar_id != 7'd5
                || ar_addr != BASE + 30'(exp_idx * 32))
                bad_ar <= bad_ar + 1;
            exp_idx <= (exp_idx + 1) % BEATS;
        end
    end

    task automatic pulse_go();
        @(negedge vid_clk) frame_go = 1'b1;
        @(negedge vid_clk) frame_go = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic ok);
        @(negedge vid_clk) pix_addr = a;
        @(posedge vid_clk);
        @(posedge vid_clk);
        @(negedge vid_clk);
        check(req, {8'h0, red, grn, blu}, {8'h0, exp_rgb(a, salt, ok)});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge mem_clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'h5EED_0042));
        mem_rst_n = 1'b0; en = 1'b0; frame_go = 1'b0; pix_addr = '0;
        salt = 16'h3A5C; err_beat = -1;
        repeat (5) @(negedge mem_clk);
        mem_rst_n = 1'b1;
        @(negedge mem_clk);
        // R12 reset state
        check("R12 beat_cnt", beat_cnt, 0);
        check("R12 err_cnt", err_cnt, 0);
        check("R12 cache_ok", {31'h0, cache_ok}, 0);
        check("R12 ar_valid", {31'h0, ar_valid}, 0);
        // R7 black before any fill
        lookup("R7 pre-fill", 32'h0000_0000, 1'b0);
        lookup("R7 pre-fill", 32'h0000_1234, 1'b0);

        // R1 disabled: frame_go must not start anything
        pulse_go();
        repeat (60) @(negedge mem_clk);
        check("R1 no request while disabled", ar_cycles, 0);
        check("R1 no beats while disabled", beat_cnt, 0);
        check("R7 still invalid", {31'h0, cache_ok}, 0);

        // first fill, with a second frame_go during it (R11)
        en = 1'b1;
        pulse_go();
        while (beat_cnt < 20) @(negedge mem_clk);
        pulse_go();
        while (!cache_ok) @(negedge vid_clk);
        repeat (300) @(negedge mem_clk);
        check("R9 beats after one fill", beat_cnt, 256);
        check("R11 mid-fill frame_go ignored", beat_cnt, 256);
        check("R10 clean fill", err_cnt, 0);
        check("R2 R3 request fields and order", bad_ar, 0);

        // directed lookups: R4 lanes, R5 decode, R6 range
        lookup("R4 pixel 0", 32'h0000_0000, 1'b1);
        lookup("R4 pixel 1", 32'h0000_0002, 1'b1);
        lookup("R4 odd byte", 32'h0000_0003, 1'b1);
        lookup("R4 lane 15", 32'h0000_001E, 1'b1);
        lookup("R4 next beat", 32'h0000_0020, 1'b1);
        lookup("R5 row 1", 32'h0000_0080, 1'b1);
        lookup("R4 last pixel", 32'h0000_1FFE, 1'b1);
        lookup("R6 first past frame", 32'h0000_2000, 1'b1);
        lookup("R6 top address", 32'hFFFF_FFFF, 1'b1);

        // R8 latency: two edges, not one
        lookup("R6 prime black", 32'h0000_2000, 1'b1);
        @(negedge vid_clk) pix_addr = 32'h0000_0456;
        @(posedge vid_clk);
        @(negedge vid_clk);
        check("R8 not after one edge", {8'h0, red, grn, blu}, 0);
        pix_addr = 32'h0000_0A9C;
        @(posedge vid_clk);
        @(negedge vid_clk);
        check("R8 first address", {8'h0, red, grn, blu}, {8'h0, exp_rgb(32'h456, salt, 1'b1)});
        @(posedge vid_clk);
        @(negedge vid_clk);
        check("R8 second address", {8'h0, red, grn, blu}, {8'h0, exp_rgb(32'hA9C, salt, 1'b1)});

        // random lookups
        for (int k = 0; k < 40; k++) begin
            a = (k % 5 == 4) ? 32'd8192 + ($urandom % 100000) : ($urandom % 8192);
            lookup("R5 R6 random", a, 1'b1);
        end

        // second fill: new data, error on the final beat (R10 with completion)
        salt = 16'hC7E1; err_beat = 255;
        pulse_go();
        while (beat_cnt < 512) @(negedge mem_clk);
        repeat (20) @(negedge mem_clk);
        check("R9 beats after two fills", beat_cnt, 512);
        check("R10 one error on last beat", err_cnt, 1);
        check("R2 R3 second fill requests", bad_ar, 0);
        lookup("R4 refilled last pixel", 32'h0000_1FFE, 1'b1);
        for (int k = 0; k < 20; k++) lookup("R5 refilled random", $urandom % 8192, 1'b1);

        // R12 reset mid-run
        @(negedge mem_clk) mem_rst_n = 1'b0;
        repeat (3) @(negedge vid_clk);
        check("R12 beat_cnt cleared", beat_cnt, 0);
        check("R12 err_cnt cleared", err_cnt, 0);
        check("R12 cache_ok cleared", {31'h0, cache_ok}, 0);
        check("R12 colour cleared", {8'h0, red, grn, blu}, 0);
        mem_rst_n = 1'b1;
        lookup("R12 R7 black after reset", 32'h0000_0100, 1'b0);

        summary();
        $finish;
    end
endmodule